// File: doc/BRIEF.md
# Verified page speculation filter

This block sits in front of the memory request path. It decides whether a hardware-generated speculative reference may go to a physical page that carries the limited-speculation attribute. Speculative traffic includes fetches and data accesses issued before earlier branches or earlier fault status are resolved, hardware instruction and data prefetches, and eager register-stack spill accesses. Such traffic can reach a page of this kind only after in-order execution has shown that the page is backed by real memory. Otherwise a speculative access to an empty hole in the physical map could raise a spurious machine check.

The filter keeps a small fully associative store of 4 KiB physical page numbers that in-order references have already verified. Each request supplies a physical address and several flags: the limited-speculation attribute, speculative or in-order, instruction fetch or data, and a fault outcome. The block answers allow or block in the same cycle from the current contents of the store. A qualifying in-order reference installs its page at the next clock edge. Page attributes, translation and fault detection are done elsewhere and arrive as inputs. A synchronous flush empties the store when page mappings change. The store depth is a parameter, and a depth of zero gives the minimal filter that has no storage at all.

Top module: `spec_page_filter`

## Requirements
- R1: Verification is tracked per 4 KiB page: address bits [11:0] take no part in the lookup or the install, so any offset within a verified page hits, and an address in the next page does not.
- R2: With `req_valid`=1, `req_spec`=1 and `req_limited`=1, `resp_allow` is 0 when the page is not held as verified. This includes every such request after reset.
- R3: With `req_valid`=1, `req_spec`=1 and `req_limited`=1, `resp_allow` is 1 when the page is held as verified.
- R4: A speculative request (`req_spec`=1) never installs its page, whatever its fault code.
- R5: An in-order instruction fetch (`req_spec`=0, `req_is_data`=0) to a limited page installs that page whatever `req_fault` holds.
- R6: An in-order data reference (`req_spec`=0, `req_is_data`=1) to a limited page installs it when `req_fault` is 0 (none), 1 (unaligned) or 2 (data debug). The code 3 (any other fault) leaves the page unverified.
- R7: `resp_allow` is 1 for every valid in-order request and for every valid request with `req_limited`=0. It is 0 whenever `req_valid`=0. Requests with `req_limited`=0 never install a page.
- R8: Installing a page that is already held takes no new entry, so the store never holds one page twice.
- R9: When all entries are occupied, a new install replaces the entries in round-robin order. The store therefore evicts the oldest installed page first.
- R10: `flush`=1 empties the store at the next edge and overrides an install requested in the same cycle.
- R11: With `ENTRIES`=0, every speculative request to a limited page is blocked, even after qualifying in-order references.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; empties the store |
| flush | input | 1 | Synchronous clear of all verified pages |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | ADDR_W | Physical address of the reference |
| req_limited | input | 1 | Page carries the limited-speculation attribute |
| req_spec | input | 1 | 1 = hardware-generated speculative, 0 = in-order |
| req_is_data | input | 1 | 1 = data reference, 0 = instruction fetch |
| req_fault | input | 2 | 0 none, 1 unaligned, 2 data debug, 3 other fault |
| resp_allow | output | 1 | Reference may proceed this cycle |

## Verification
The hardest situation to reach is the one where the no-duplicate rule changes which page gets evicted. A page that is installed twice looks the same as one installed once until the store wraps around. The stimulus installs page A, then page B, then A again, then six more pages and one extra, and then probes both A and B. If a duplicate had taken a slot, B would be evicted in place of A. A second instance with zero entries receives the same stimulus, so the minimal variant is checked on every cycle against its own model.

// File: rtl/spf_pkg.sv
package spf_pkg;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_UNALIGNED = 2'd1,
        FLT_DBG       = 2'd2,
        FLT_OTHER     = 2'd3
    } fault_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 0) ? $clog2(n + 1) : 1;
    endfunction

endpackage

// File: rtl/spf_qualify.sv
module spf_qualify
    import spf_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_spec,
    input  logic       req_limited,
    input  logic       req_is_data,
    input  logic [1:0] req_fault,
    output logic       install_req
);

    logic data_ok;

    always_comb begin
        unique case (fault_e'(req_fault))
            FLT_NONE, FLT_UNALIGNED, FLT_DBG: data_ok = 1'b1;
            default:                          data_ok = 1'b0;
        endcase
        // fetches verify regardless of their later fault outcome
        install_req = req_valid && !req_spec && req_limited
                      && (!req_is_data || data_ok);
    end

endmodule

// File: rtl/spf_page_store.sv
module spf_page_store
    import spf_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned ADDR_W  = 48,
    parameter int unsigned PAGE_SHIFT = 12,
    localparam int unsigned PN_W  = ADDR_W - PAGE_SHIFT,
    localparam int unsigned MW    = (ENTRIES > 0) ? ENTRIES : 1,
    localparam int unsigned CNT_W = cnt_width(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_req,
    output logic              hit,
    output logic [MW-1:0]     match_vec,
    output logic [CNT_W-1:0]  fill_cnt
);

    generate
        if (ENTRIES == 0) begin : g_none
            assign hit       = 1'b0;
            assign match_vec = '0;
            assign fill_cnt  = '0;
        end else begin : g_cam
            localparam int unsigned IDX_W = idx_width(ENTRIES);

            typedef struct packed {
                logic [ENTRIES-1:0]           valid;
                logic [ENTRIES-1:0][PN_W-1:0] tag;
                logic [IDX_W-1:0]             ptr;
                logic [CNT_W-1:0]             fill;
            } store_t;

            store_t             st_d, st_q;
            logic [PN_W-1:0]    pn;
            logic [ENTRIES-1:0] match;

            assign pn = PN_W'(addr >> PAGE_SHIFT);

            always_comb begin
                for (int i = 0; i < ENTRIES; i++) begin
                    match[i] = st_q.valid[i] && (st_q.tag[i] == pn);
                end
            end

            assign hit       = |match;
            assign match_vec = match;
            assign fill_cnt  = st_q.fill;

            always_comb begin
                st_d = st_q;
                if (flush) begin
                    st_d.valid = '0;
                    st_d.ptr   = '0;
                    st_d.fill  = '0;
                end else if (wr_req && !hit) begin
                    st_d.tag[st_q.ptr]   = pn;
                    st_d.valid[st_q.ptr] = 1'b1;
                    st_d.ptr = (st_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.ptr + 1'b1;
                    if (st_q.fill != CNT_W'(ENTRIES)) begin
                        st_d.fill = st_q.fill + 1'b1;
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end
        end
    endgenerate

endmodule

// File: rtl/spec_page_filter.sv
module spec_page_filter
    import spf_pkg::*;
#(
    parameter int unsigned ADDR_W     = 48,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned ENTRIES    = 8,
    localparam int unsigned MW    = (ENTRIES > 0) ? ENTRIES : 1,
    localparam int unsigned CNT_W = cnt_width(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_limited,
    input  logic              req_spec,
    input  logic              req_is_data,
    input  logic [1:0]        req_fault,
    output logic              resp_allow
);

    logic             install_req;
    logic             page_hit;
    logic [MW-1:0]    page_match;
    logic [CNT_W-1:0] page_fill;

    spf_qualify u_qual (
        .req_valid   (req_valid),
        .req_spec    (req_spec),
        .req_limited (req_limited),
        .req_is_data (req_is_data),
        .req_fault   (req_fault),
        .install_req (install_req)
    );

    spf_page_store #(
        .ENTRIES    (ENTRIES),
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .addr      (req_addr),
        .wr_req    (install_req),
        .hit       (page_hit),
        .match_vec (page_match),
        .fill_cnt  (page_fill)
    );

    always_comb begin
        resp_allow = req_valid && (!req_spec || !req_limited || page_hit);
    end

endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned MW    = (ENTRIES > 0) ? ENTRIES : 1,
    localparam int unsigned CNT_W = spf_pkg::cnt_width(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_valid,
    input logic             req_limited,
    input logic             req_spec,
    input logic             req_is_data,
    input logic [1:0]       req_fault,
    input logic             resp_allow,
    input logic             install_req,
    input logic             page_hit,
    input logic [MW-1:0]    page_match,
    input logic [CNT_W-1:0] page_fill
);

    a_r2_block_unverified: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_spec && req_limited && !page_hit |-> !resp_allow);

    a_r3_allow_verified: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_spec && req_limited && page_hit |-> resp_allow);

    a_r4_spec_no_install: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_spec |-> !install_req);

    a_r4_spec_fill_stable: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_spec && !flush |=> $stable(page_fill));

    a_r6_other_fault: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_spec && req_is_data && (req_fault == 2'd3) |-> !install_req);

    a_r7_plain_pass: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_limited |-> resp_allow);

    a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(page_match));

    a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        page_fill <= CNT_W'(ENTRIES));

    a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (page_fill == '0) && (page_match == '0));

    generate
        if (ENTRIES == 0) begin : g_zero
            a_r11_zero_block: assert property (@(posedge clk) disable iff (!rst_n)
                req_valid && req_spec && req_limited |-> !resp_allow);
        end
    endgenerate

endmodule

bind spec_page_filter spf_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .req_valid   (req_valid),
    .req_limited (req_limited),
    .req_spec    (req_spec),
    .req_is_data (req_is_data),
    .req_fault   (req_fault),
    .resp_allow  (resp_allow),
    .install_req (install_req),
    .page_hit    (page_hit),
    .page_match  (page_match),
    .page_fill   (page_fill)
);

// File: tb/sim_spec_page_filter.sv
module sim_spec_page_filter;

    localparam int unsigned ADDR_W = 48;
    localparam int unsigned DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_limited = 1'b0;
    logic              req_spec = 1'b0;
    logic              req_is_data = 1'b0;
    logic [1:0]        req_fault = 2'd0;
    logic              allow0, allow1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    longint unsigned held[$];

    always #4 clk = ~clk;

    spec_page_filter #(.ADDR_W(ADDR_W), .ENTRIES(DEPTH)) u0 (
        .clk, .rst_n, .flush, .req_valid, .req_addr, .req_limited,
        .req_spec, .req_is_data, .req_fault, .resp_allow(allow0)
    );

    spec_page_filter #(.ADDR_W(ADDR_W), .ENTRIES(0)) u1 (
        .clk, .rst_n, .flush, .req_valid, .req_addr, .req_limited,
        .req_spec, .req_is_data, .req_fault, .resp_allow(allow1)
    );

    function automatic logic [ADDR_W-1:0] mk(input longint unsigned pn, input int off);
        return ADDR_W'((pn << 12) | longint'(off & 32'hFFF));
    endfunction

    function automatic bit is_held(input longint unsigned pn);
        foreach (held[i]) if (held[i] == pn) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b page=%0h", tag, act, exp, req_addr >> 12);
        end
    endtask

    task automatic step(input string tag, input bit v, input bit spec, input bit lim,
                        input bit data, input logic [1:0] flt, input longint unsigned pn,
                        input int off, input bit fl);
        bit qual, e0, e1;
        @(negedge clk);
        req_valid = v; req_spec = spec; req_limited = lim;
        req_is_data = data; req_fault = flt; req_addr = mk(pn, off); flush = fl;
        #3;
        e0 = v && (!spec || !lim || is_held(pn));
        e1 = v && (!spec || !lim);
        check(tag, allow0, e0);
        check({tag, " R11"}, allow1, e1);
        qual = v && !spec && lim && (!data || flt != 2'd3);
        if (fl) held.delete();
        else if (qual && !is_held(pn)) begin
            if (held.size() == DEPTH) void'(held.pop_front());
            held.push_back(pn);
        end
    endtask

    task automatic probe(input string tag, input longint unsigned pn, input int off);
        step(tag, 1, 1, 1, 1, 2'd0, pn, off, 0);
    endtask

    task automatic fetch(input string tag, input longint unsigned pn, input logic [1:0] flt);
        step(tag, 1, 0, 1, 0, flt, pn, 0, 0);
    endtask

    task automatic dref(input string tag, input longint unsigned pn, input logic [1:0] flt);
        step(tag, 1, 0, 1, 1, flt, pn, 'h40, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // reset state
        step("R7 idle", 0, 0, 0, 0, 2'd0, 5, 0, 0);
        probe("R2 after reset", 5, 0);
        // fetch verifies even when faulting
        fetch("R5 fetch faulting", 5, 2'd3);
        probe("R3 verified", 5, 'h123);
        probe("R1 other offset", 5, 'hFFF);
        probe("R1 next page", 6, 0);
        // data fault qualification
        dref("R6 other fault", 6, 2'd3);
        probe("R6 other fault no install", 6, 0);
        dref("R6 unaligned", 7, 2'd1);
        dref("R6 debug", 8, 2'd2);
        dref("R6 clean", 9, 2'd0);
        probe("R6 unaligned verified", 7, 0);
        probe("R6 debug verified", 8, 0);
        probe("R6 clean verified", 9, 'h800);
        // speculative never installs
        step("R4 spec fetch", 1, 1, 1, 0, 2'd0, 10, 0, 0);
        step("R4 spec data", 1, 1, 1, 1, 2'd1, 10, 0, 0);
        probe("R4 still blocked", 10, 0);
        step("R7 spec plain", 1, 1, 0, 1, 2'd0, 10, 0, 0);
        step("R7 inorder plain", 1, 0, 0, 1, 2'd0, 11, 0, 0);
        probe("R7 plain no install", 11, 0);
        // flush wins over a same-cycle install
        step("R10 flush+install", 1, 0, 1, 0, 2'd0, 12, 0, 1);
        probe("R10 flushed", 5, 0);
        probe("R10 flushed", 9, 0);
        probe("R10 install dropped", 12, 0);
        // duplicate and round-robin
        fetch("R8 A", 20, 2'd0);
        fetch("R8 B", 21, 2'd0);
        fetch("R8 A again", 20, 2'd0);
        for (int p = 22; p <= 28; p++) fetch("R9 fill", p, 2'd0);
        probe("R8 A evicted", 20, 0);
        probe("R8 B kept", 21, 0);
        for (int p = 20; p <= 28; p++) probe("R9 after wrap", p, 0);
        for (int p = 29; p <= 45; p++) begin
            fetch("R9 churn", p, 2'd0);
            probe("R9 oldest", p - 8, 0);
            probe("R9 newest", p, 'h10);
        end
        for (int p = 30; p <= 46; p++) probe("R9 final", p, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule